// File: doc/BRIEF.md
# Sign-Bit Decrementer Timer

This block is a down-counting timer. It steps once on each pulse of a time-base tick enable and raises an interrupt when the count passes from zero to minus one. Software loads the count through a write port and reads it back through a read port. The counter has two active widths: a 32-bit narrow width and a wider width chosen by a parameter. A mode input picks between them.

The interrupt is signalled from the sign bit of the active width, in one of two ways. In edge mode, a write raises the interrupt only when it takes the sign bit from clear to set. The pending interrupt stays until it is delivered, and the block flags that delivery should clear it. In level mode, a negative write raises the interrupt, and a non-negative write removes it. A setup pulse reloads the counter with all ones and leaves no interrupt pending. A parameter builds a hypervisor-style instance, in which a power-save suppress input discards any expiry that arrives while it is set.

Top module: `decr_timer`

## Requirements
- R1: After reset, the count is all ones (narrow read `0xFFFFFFFF`), `irq` is low, and with both mode flags low `clr_on_deliver` is low.
- R2: A write keeps only the active width of `wr_data` (32 bits when `wide_mode`=0, WIDE_W=56 bits when `wide_mode`=1) and sign-extends it from the top active bit (bit 31 or bit 55).
- R3: Each cycle with `tick` high and no write or setup lowers the count by one, wrapping within the active width. With `tick` low the count holds. A write in the same cycle as a tick takes the written value, and the tick is lost.
- R4: A tick that takes the count from zero to minus one raises `irq` in the next cycle, in every mode.
- R5: A write whose sign-extended value is 0, 1 or 2 raises `irq`, unless level mode is on.
- R6: With `level_mode`=1, a negative write raises `irq`, and a non-negative write (including 0 to 2) lowers it.
- R7: With `edge_mode`=1, a negative write raises `irq` only if the previous count had its active top bit clear. Otherwise `irq` keeps its value.
- R8: `clr_on_deliver` is high exactly when `edge_mode`=1 and `level_mode`=0. Only then does `ack` clear `irq`. In level mode `ack` leaves `irq` unchanged.
- R9: `rd_data` returns the full sign-extended count when `wide_mode`=1, and only the low 32 bits (zero-extended) when `wide_mode`=0.
- R10: `init_load` sets the count to all ones and clears `irq`, taking priority over a write in the same cycle.
- R11: With HYP_VARIANT=1, a raise (from a write or from an underflow) that happens while `suppress` is high is discarded: `irq` does not rise then or later because of it.
- R12: When a raise and an `ack` fall in the same cycle, the raise wins and `irq` ends high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base tick enable; decrements the count |
| wr_en | input | 1 | Write strobe for the count |
| wr_data | input | 64 | Value to write |
| init_load | input | 1 | Setup pulse: count to all ones, interrupt cleared |
| wide_mode | input | 1 | Selects the wide active width |
| edge_mode | input | 1 | Sign-bit edge signalling |
| level_mode | input | 1 | Sign-bit level signalling |
| ack | input | 1 | Interrupt delivered |
| suppress | input | 1 | Power-save suppress (hypervisor instance only) |
| rd_data | output | 64 | Current count as read |
| irq | output | 1 | Decrementer interrupt request |
| clr_on_deliver | output | 1 | Delivery clears the interrupt |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before anything else happens. The hold check also assumes that `wide_mode` changes only between idle cycles. It treats a change of width as a legal change in the read value. The underflow check looks at zero through the read port, so it relies on the narrow read showing the masked low bits. The random stimulus toggles the mode flags and the width only on about one cycle in sixteen. It biases written data toward 0 to 4 and toward the two sign boundaries, so that underflow, sign edges and suppress windows all happen often.

// File: rtl/decr_pkg.sv
package decr_pkg;
   localparam int unsigned DEC_REG_W = 64;
   typedef logic [DEC_REG_W-1:0] dec_word_t;

   // sign-extend v from bit w-1 to the full register width
   function automatic dec_word_t dec_sext(input dec_word_t v, input int unsigned w);
      dec_word_t r;
      for (int i = 0; i < DEC_REG_W; i++) begin
         r[i] = (i < int'(w)) ? v[i] : v[w-1];
      end
      return r;
   endfunction

   // ones in the low w bits
   function automatic dec_word_t dec_mask(input int unsigned w);
      dec_word_t r;
      for (int i = 0; i < DEC_REG_W; i++) begin
         r[i] = (i < int'(w));
      end
      return r;
   endfunction
endpackage

// File: rtl/dec_write_fmt.sv
module dec_write_fmt
   import decr_pkg::*;
#(
   parameter int unsigned NARROW_W = 32,
   parameter int unsigned WIDE_W   = 56
) (
   input  dec_word_t wr_data,
   input  logic      wide_mode,
   output dec_word_t wr_val,
   output logic      wr_neg,
   output logic      wr_small
);
   localparam int unsigned SMALL_LIM = 3;
   int unsigned act_w;

   always_comb begin
      act_w    = wide_mode ? WIDE_W : NARROW_W;
      wr_val   = dec_sext(wr_data, act_w);
      wr_neg   = wr_val[DEC_REG_W-1];
      wr_small = (wr_val < dec_word_t'(SMALL_LIM));
   end
endmodule

// File: rtl/dec_count_core.sv
module dec_count_core
   import decr_pkg::*;
#(
   parameter int unsigned NARROW_W = 32,
   parameter int unsigned WIDE_W   = 56
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      init_load,
   input  logic      wr_en,
   input  dec_word_t wr_val,
   input  logic      tick,
   input  logic      wide_mode,
   output dec_word_t cnt,
   output logic      cnt_zero,
   output logic      cnt_msb
);
   int unsigned act_w;
   dec_word_t   cnt_dec;

   always_comb begin
      act_w    = wide_mode ? WIDE_W : NARROW_W;
      cnt_zero = ((cnt & dec_mask(act_w)) == '0);
      cnt_msb  = cnt[act_w-1];
      cnt_dec  = dec_sext(cnt - dec_word_t'(1), act_w);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '1;
      else if (init_load)  cnt <= '1;
      else if (wr_en)      cnt <= wr_val;
      else if (tick)       cnt <= cnt_dec;
   end
endmodule

// File: rtl/dec_irq_ctrl.sv
module dec_irq_ctrl #(
   parameter bit HYP_VARIANT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raise,
   input  logic lower,
   input  logic ack,
   input  logic clr_ok,
   input  logic suppress,
   output logic irq
);
   logic raise_ok;

   generate
      if (HYP_VARIANT) begin : g_hyp
         assign raise_ok = raise & ~suppress;
      end else begin : g_plain
         logic unused_suppress;
         assign unused_suppress = suppress;
         assign raise_ok = raise;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)               irq <= 1'b0;
      else if (lower)           irq <= 1'b0;
      else if (raise_ok)        irq <= 1'b1;
      else if (ack && clr_ok)   irq <= 1'b0;
   end
endmodule

// File: rtl/decr_timer.sv
module decr_timer
   import decr_pkg::*;
#(
   parameter int unsigned NARROW_W    = 32,
   parameter int unsigned WIDE_W      = 56,
   parameter bit          HYP_VARIANT = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 wr_en,
   input  logic [DEC_REG_W-1:0] wr_data,
   input  logic                 init_load,
   input  logic                 wide_mode,
   input  logic                 edge_mode,
   input  logic                 level_mode,
   input  logic                 ack,
   input  logic                 suppress,
   output logic [DEC_REG_W-1:0] rd_data,
   output logic                 irq,
   output logic                 clr_on_deliver
);
   generate
      if (NARROW_W < 2 || NARROW_W >= WIDE_W) begin : g_bad_narrow
         $error("decr_timer: NARROW_W must be at least 2 and below WIDE_W");
      end
      if (WIDE_W > DEC_REG_W) begin : g_bad_wide
         $error("decr_timer: WIDE_W exceeds the register width");
      end
   endgenerate

   dec_word_t wr_val, cnt;
   logic      wr_neg, wr_small, cnt_zero, cnt_msb;
   logic      wr_raise, wr_lower, raise, lower;

   dec_write_fmt #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_fmt (
      .wr_data  (wr_data),
      .wide_mode(wide_mode),
      .wr_val   (wr_val),
      .wr_neg   (wr_neg),
      .wr_small (wr_small)
   );

   dec_count_core #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .init_load(init_load),
      .wr_en    (wr_en),
      .wr_val   (wr_val),
      .tick     (tick),
      .wide_mode(wide_mode),
      .cnt      (cnt),
      .cnt_zero (cnt_zero),
      .cnt_msb  (cnt_msb)
   );

   always_comb begin
      clr_on_deliver = edge_mode & ~level_mode;
      wr_raise = wr_small | (level_mode & wr_neg) | (edge_mode & wr_neg & ~cnt_msb);
      wr_lower = level_mode & ~wr_neg;
      raise    = ~init_load & (wr_en ? wr_raise : (tick & cnt_zero));
      lower    = init_load | (wr_en & wr_lower);
      rd_data  = wide_mode ? cnt : (cnt & dec_mask(NARROW_W));
   end

   dec_irq_ctrl #(.HYP_VARIANT(HYP_VARIANT)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .raise   (raise),
      .lower   (lower),
      .ack     (ack),
      .clr_ok  (clr_on_deliver),
      .suppress(suppress),
      .irq     (irq)
   );
endmodule

// File: rtl/decr_timer_chk.sv
module decr_timer_chk #(
   parameter int unsigned NARROW_W    = 32,
   parameter int unsigned WIDE_W      = 56,
   parameter bit          HYP_VARIANT = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        tick,
   input logic        wr_en,
   input logic [63:0] wr_data,
   input logic        init_load,
   input logic        wide_mode,
   input logic        edge_mode,
   input logic        level_mode,
   input logic        ack,
   input logic        suppress,
   input logic [63:0] rd_data,
   input logic        irq,
   input logic        clr_on_deliver
);
   logic wr_sign;
   assign wr_sign = wide_mode ? wr_data[WIDE_W-1] : wr_data[NARROW_W-1];

   // R10
   init_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_load |=> (!irq && rd_data[31:0] == 32'hFFFF_FFFF));

   // R6
   level_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !init_load && level_mode && !wr_sign) |=> !irq);

   // R4
   underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_en && !init_load && rd_data == '0 && !suppress) |=> irq);

   // R8
   level_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && level_mode && !wr_en && !init_load && !tick) |=> $stable(irq));

   // R3
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !wr_en && !init_load) |=> ((wide_mode != $past(wide_mode)) || $stable(rd_data)));

   generate
      if (HYP_VARIANT) begin : g_sup
         // R11
         suppress_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (suppress && !irq) |=> !irq);
      end
   endgenerate
endmodule

bind decr_timer decr_timer_chk #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W), .HYP_VARIANT(HYP_VARIANT)) u_chk (.*);

// File: tb/tb_decr_timer.sv
`timescale 1ns/1ps
module tb_decr_timer;
   localparam int NW = 32;
   localparam int WW = 56;

   logic        clk = 1'b0;
   logic        rst_n, tick, wr_en, init_load, wide_mode, edge_mode, level_mode, ack, suppress;
   logic [63:0] wr_data, rd_data;
   logic        irq, clr_on_deliver;

   int checks = 0;
   int errors = 0;
   logic [63:0] m_cnt;
   logic        m_irq;

   always #5 clk = ~clk;

   decr_timer dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
      .init_load(init_load), .wide_mode(wide_mode), .edge_mode(edge_mode),
      .level_mode(level_mode), .ack(ack), .suppress(suppress),
      .rd_data(rd_data), .irq(irq), .clr_on_deliver(clr_on_deliver)
   );

   function automatic logic [63:0] sx(input logic [63:0] v, input int w);
      logic [63:0] r;
      for (int i = 0; i < 64; i++) r[i] = (i < w) ? v[i] : v[w-1];
      return r;
   endfunction

   function automatic logic [63:0] exp_rd();
      return wide_mode ? m_cnt : {32'h0, m_cnt[31:0]};
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, expv);
      end
   endtask

   task automatic cyc(input string tag);
      int          w;
      logic [63:0] v, n_cnt;
      logic        raise, lower, n_irq;
      w = wide_mode ? WW : NW;
      raise = 1'b0; lower = 1'b0; n_cnt = m_cnt;
      if (init_load) begin
         n_cnt = '1; lower = 1'b1;
      end else if (wr_en) begin
         v = sx(wr_data, w);
         raise = (v < 3) || (level_mode && v[63]) || (edge_mode && v[63] && !m_cnt[w-1]);
         lower = level_mode && !v[63];
         n_cnt = v;
      end else if (tick) begin
         raise = ((m_cnt & sx(64'h0, 0) ) == 64'h0) && (sx(m_cnt, w) == 64'h0);
         n_cnt = sx(m_cnt - 64'd1, w);
      end
      if (suppress) raise = 1'b0;
      if (lower)                              n_irq = 1'b0;
      else if (raise)                         n_irq = 1'b1;
      else if (ack && edge_mode && !level_mode) n_irq = 1'b0;
      else                                    n_irq = m_irq;
      @(posedge clk);
      m_cnt = n_cnt;
      m_irq = n_irq;
      @(negedge clk);
      chk({tag, " rd_data"}, rd_data, exp_rd());
      chk({tag, " irq"}, {63'h0, irq}, {63'h0, m_irq});
      chk({tag, " clr_on_deliver (R8)"}, {63'h0, clr_on_deliver}, {63'h0, edge_mode & ~level_mode});
      wr_en = 1'b0; tick = 1'b0; init_load = 1'b0; ack = 1'b0;
   endtask

   task automatic wr(input logic [63:0] d, input string tag);
      wr_en = 1'b1; wr_data = d; cyc(tag);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; tick = 0; wr_en = 0; init_load = 0; wide_mode = 0;
      edge_mode = 0; level_mode = 0; ack = 0; suppress = 0; wr_data = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      m_cnt = '1; m_irq = 1'b0;
      chk("R1 reset rd", rd_data, 64'hFFFF_FFFF);
      chk("R1 reset irq", {63'h0, irq}, 64'h0);
      chk("R1 reset cod", {63'h0, clr_on_deliver}, 64'h0);

      edge_mode = 1'b1;
      wr(64'h1_2345_6789, "R2 truncate");
      chk("R2 narrow value", rd_data, 64'h2345_6789);
      wr(64'h8000_0010, "R7 sign edge");
      chk("R7 raise on 0->1", {63'h0, irq}, 64'h1);
      wr(64'h9000_0000, "R7 already negative");
      ack = 1'b1; cyc("R8 ack edge");
      chk("R8 ack clears", {63'h0, irq}, 64'h0);
      wr(64'h9000_0000, "R7 no edge");
      chk("R7 no raise when msb set", {63'h0, irq}, 64'h0);

      wide_mode = 1'b1;
      wr(64'h0080_0000_0000_0005, "R9 wide write");
      chk("R9 wide sext", rd_data, 64'hFF80_0000_0000_0005);
      wide_mode = 1'b0;
      cyc("R9 narrow read");
      chk("R9 narrow low bits", rd_data, 64'h5);

      wr_en = 1'b1; wr_data = 64'd2; tick = 1'b1; cyc("R3 write beats tick");
      chk("R3 write wins", rd_data, 64'd2);
      chk("R5 small raise", {63'h0, irq}, 64'h1);
      ack = 1'b1; cyc("R8 ack");
      tick = 1'b1; cyc("R3 tick");
      cyc("R3 idle hold");
      chk("R3 hold", rd_data, 64'd1);
      tick = 1'b1; cyc("R3 tick to zero");
      tick = 1'b1; cyc("R4 underflow");
      chk("R4 underflow irq", {63'h0, irq}, 64'h1);
      chk("R4 underflow value", rd_data, 64'hFFFF_FFFF);

      level_mode = 1'b1;
      ack = 1'b1; cyc("R8 level ack ignored");
      chk("R8 level ack keeps irq", {63'h0, irq}, 64'h1);
      wr(64'd5, "R6 positive lowers");
      chk("R6 lowered", {63'h0, irq}, 64'h0);
      wr(64'hFFFF_FFF0, "R6 negative raises");
      chk("R6 raised", {63'h0, irq}, 64'h1);
      wr(64'd1, "R6 small lowers");
      chk("R6 small lowered", {63'h0, irq}, 64'h0);

      level_mode = 1'b0; suppress = 1'b1;
      wr(64'd0, "R11 write suppressed");
      chk("R11 write discarded", {63'h0, irq}, 64'h0);
      wr(64'd1, "R11 setup");
      tick = 1'b1; cyc("R11 tick");
      tick = 1'b1; cyc("R11 underflow suppressed");
      suppress = 1'b0;
      cyc("R11 after suppress");
      chk("R11 not held", {63'h0, irq}, 64'h0);

      wr(64'd0, "R12 setup");
      ack = 1'b1; cyc("R12 clear");
      tick = 1'b1; ack = 1'b1; cyc("R12 raise beats ack");
      chk("R12 irq high", {63'h0, irq}, 64'h1);

      init_load = 1'b1; wr_en = 1'b1; wr_data = 64'd5; cyc("R10 init beats write");
      chk("R10 all ones", rd_data, 64'hFFFF_FFFF);
      chk("R10 irq cleared", {63'h0, irq}, 64'h0);
      level_mode = 1'b1; init_load = 1'b1; cyc("R10 init level mode");
      chk("R10 no irq in level", {63'h0, irq}, 64'h0);

      void'($urandom(32'h5EED_0042));
      for (int n = 0; n < 3000; n++) begin
         int r;
         r = $urandom % 16;
         if (r == 0) begin
            wide_mode = $urandom % 2; edge_mode = $urandom % 2; level_mode = $urandom % 2;
         end
         suppress  = ($urandom % 8) == 0;
         wr_en     = ($urandom % 4) == 0;
         tick      = ($urandom % 2) == 1;
         ack       = ($urandom % 6) == 0;
         init_load = ($urandom % 97) == 0;
         case ($urandom % 5)
            0: wr_data = 64'($urandom % 5);
            1: wr_data = {32'h0, 32'h8000_0000 - 32'($urandom % 3)};
            2: wr_data = 64'h0080_0000_0000_0000 - 64'($urandom % 3);
            3: wr_data = {$urandom, $urandom};
            default: wr_data = 64'($urandom % 8);
         endcase
         cyc("R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12 random");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule